// File: doc/BRIEF.md
# Repeating Alarm Match Unit

This block holds four alarm registers (seconds, minutes, hours, day of month, all BCD) and an interrupt-enable register behind a byte-wide register port. A separate calendar block supplies the current BCD time of day and a one-second tick. On each tick the unit compares the alarm against the time and, if they match and the interrupt is enabled, drives a one-cycle pulse on its interrupt output.

Bit 7 of each alarm register is a repeat mask. The four mask bits together select one of five repeat rates: monthly, daily, hourly, once a minute or every second. Writes whose BCD field is out of range are dropped without any side effect. Calendar counting is done outside this block.

Control is a three-state sequencer. **ST_IDLE** waits for a tick. On the **tick** transition it latches the match result and moves to **ST_EVAL**. From there, **hit** (match and enable set) goes to **ST_PULSE**, and **miss** goes back to ST_IDLE. **ST_PULSE** drives the interrupt for one cycle and returns to ST_IDLE through **done**. A tick that arrives while the sequencer is in ST_EVAL or ST_PULSE is not acted on.

Top module: `alarm_match_top`

## Requirements
- R1: After reset, all five registers read 0x00 and `alarm_irq` is low.
- R2: Register offsets on `reg_addr` are: 0 seconds, 1 minutes, 2 hours, 3 date, 4 interrupt enable. A read returns the last accepted byte, including bit 7. Offset 4 reads back only bit 7 (the enable), with every other bit 0. Offsets 5 to 7 read 0x00.
- R3: A write to seconds or minutes decodes bits [6:4] as the BCD tens digit and bits [3:0] as the units digit, giving tens*10 + units. The whole byte is stored only if that value is 0 to 59. Otherwise the register is unchanged.
- R4: A write to hours decodes bits [5:0] as BCD the same way. It is stored only if the value is 0 to 23.
- R5: A write to date decodes bits [5:0] as BCD. It is stored only if the value is nonzero.
- R6: With all mask bits clear, a tick fires the alarm only when all four fields match: seconds [6:0], minutes [6:0], hours [5:0] and date [5:0].
- R7: With only the date mask set, a tick fires when seconds, minutes and hours match (daily).
- R8: With only the date and hours masks set, a tick fires when seconds and minutes match (hourly).
- R9: With the date, hours and minutes masks set and the seconds mask clear, a tick fires when seconds match (once a minute).
- R10: Any other mask combination, including all four set, fires on every tick.
- R11: A firing drives `alarm_irq` high for exactly one cycle, in the second cycle after the clock edge that samples `sec_tick`. At most one pulse is produced per tick.
- R12: With the enable bit (offset 4, bit 7) clear, no pulse is produced, even on a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tod_sec | input | 7 | Current seconds, BCD |
| tod_min | input | 7 | Current minutes, BCD |
| tod_hour | input | 6 | Current hours, BCD |
| tod_date | input | 6 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| alarm_irq | output | 1 | One-cycle alarm interrupt pulse |

## Verification
A wrong register value shows up at once on `reg_rdata`, so every accepted or rejected write is read back before the next stimulus. A wrong rate decode or compare shows up two cycles after a tick: the pulse is present when it should be absent, or the reverse. The sequencer is checked on every cycle, so a pulse that lasts too long, comes twice, or comes without a tick is reported in the cycle it appears.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int unsigned OFS_SEC  = 0;
    localparam int unsigned OFS_MIN  = 1;
    localparam int unsigned OFS_HOUR = 2;
    localparam int unsigned OFS_DATE = 3;
    localparam int unsigned OFS_IEN  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_PULSE = 2'd2
    } seq_state_t;

    typedef enum logic [2:0] {
        RATE_MONTH,
        RATE_DAY,
        RATE_HOUR,
        RATE_MINUTE,
        RATE_SECOND
    } rate_t;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] date;
    } alarm_regs_t;

    function automatic logic [7:0] bcd_value(input logic [6:0] v);
        return 8'(v[6:4]) * 8'd10 + 8'(v[3:0]);
    endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
    import alarm_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output alarm_regs_t       regs,
    output logic              irq_en
);
    logic [7:0] dec_sec_min;
    logic [7:0] dec_hour_date;
    logic       ok_sec_min;
    logic       ok_hour;
    logic       ok_date;

    always_comb begin
        dec_sec_min   = bcd_value(wdata[6:0]);
        dec_hour_date = bcd_value({1'b0, wdata[5:0]});
        ok_sec_min    = (dec_sec_min <= 8'd59);
        ok_hour       = (dec_hour_date <= 8'd23);
        ok_date       = (dec_hour_date != 8'd0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs   <= '0;
            irq_en <= 1'b0;
        end else if (wr) begin
            case (32'(addr))
                OFS_SEC:  if (ok_sec_min) regs.sec  <= wdata;
                OFS_MIN:  if (ok_sec_min) regs.min  <= wdata;
                OFS_HOUR: if (ok_hour)    regs.hour <= wdata;
                OFS_DATE: if (ok_date)    regs.date <= wdata;
                OFS_IEN:  irq_en <= wdata[7];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (32'(addr))
            OFS_SEC:  rdata = regs.sec;
            OFS_MIN:  rdata = regs.min;
            OFS_HOUR: rdata = regs.hour;
            OFS_DATE: rdata = regs.date;
            OFS_IEN:  rdata = {irq_en, 7'd0};
            default:  rdata = 8'd0;
        endcase
    end

    // R3: tens digit above 5 can never be accepted
    p_reject_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && 32'(addr) == OFS_SEC && wdata[6:4] > 3'd5) |=> $stable(regs.sec));
    // R4: hours with tens digit 3 are out of range
    p_reject_hour_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && 32'(addr) == OFS_HOUR && wdata[5:4] == 2'd3) |=> $stable(regs.hour));
    // R5: zero date rejected
    p_reject_date_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && 32'(addr) == OFS_DATE && wdata[5:0] == 6'd0) |=> $stable(regs.date));
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
    import alarm_pkg::*;
(
    input  alarm_regs_t regs,
    input  logic [6:0]  tod_sec,
    input  logic [6:0]  tod_min,
    input  logic [5:0]  tod_hour,
    input  logic [5:0]  tod_date,
    output rate_t       rate,
    output logic        match
);
    logic eq_sec, eq_min, eq_hour, eq_date;

    always_comb begin
        eq_sec  = (regs.sec[6:0]  == tod_sec);
        eq_min  = (regs.min[6:0]  == tod_min);
        eq_hour = (regs.hour[5:0] == tod_hour);
        eq_date = (regs.date[5:0] == tod_date);

        case ({regs.date[7], regs.hour[7], regs.min[7], regs.sec[7]})
            4'b0000: rate = RATE_MONTH;
            4'b1000: rate = RATE_DAY;
            4'b1100: rate = RATE_HOUR;
            4'b1110: rate = RATE_MINUTE;
            default: rate = RATE_SECOND;
        endcase

        unique case (rate)
            RATE_MONTH:  match = eq_sec && eq_min && eq_hour && eq_date;
            RATE_DAY:    match = eq_sec && eq_min && eq_hour;
            RATE_HOUR:   match = eq_sec && eq_min;
            RATE_MINUTE: match = eq_sec;
            default:     match = 1'b1;
        endcase
    end
endmodule

// File: rtl/alarm_seq.sv
module alarm_seq
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic irq_en,
    output logic irq
);
    seq_state_t state, state_nx;
    logic       hit_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tick) state_nx = ST_EVAL;
            ST_EVAL:  state_nx = (hit_q && irq_en) ? ST_PULSE : ST_IDLE;
            ST_PULSE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hit_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && tick) hit_q <= match;
        end
    end

    always_comb irq = (state == ST_PULSE);

    // R11: pulse lasts one cycle
    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R11: pulse is two cycles after a sampled tick
    p_pulse_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick, 2));
    // R12: no pulse unless enabled at decision time
    p_irq_enabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en));
endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
    import alarm_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [6:0]        tod_sec,
    input  logic [6:0]        tod_min,
    input  logic [5:0]        tod_hour,
    input  logic [5:0]        tod_date,
    input  logic              sec_tick,
    output logic              alarm_irq
);
    alarm_regs_t regs;
    logic        irq_en;
    logic        match;
    rate_t       rate;

    alarm_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .regs(regs), .irq_en(irq_en)
    );

    alarm_compare u_cmp (
        .regs(regs), .tod_sec(tod_sec), .tod_min(tod_min),
        .tod_hour(tod_hour), .tod_date(tod_date), .rate(rate), .match(match)
    );

    alarm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .match(match),
        .irq_en(irq_en), .irq(alarm_irq)
    );

    // R10: all masks set selects every-second rate
    p_all_masks_second_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.sec[7] && regs.min[7] && regs.hour[7] && regs.date[7]) |-> match);
endmodule

// File: tb/alarm_match_tb_top.sv
module alarm_match_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] tod_sec = '0;
    logic [6:0] tod_min = '0;
    logic [5:0] tod_hour = '0;
    logic [5:0] tod_date = '0;
    logic       sec_tick = 1'b0;
    logic       alarm_irq;

    int checks = 0;
    int errors = 0;
    bit exp_q[$];
    string tag_q[$];
    logic [1:0] tick_hist = '0;
    bit done = 0;

    always #4 clk = ~clk;

    alarm_match_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tod_sec(tod_sec),
        .tod_min(tod_min), .tod_hour(tod_hour), .tod_date(tod_date),
        .sec_tick(sec_tick), .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic tick(input string req, input logic [6:0] s, input logic [6:0] m,
                        input logic [5:0] h, input logic [5:0] d, input bit exp);
        @(negedge clk);
        tod_sec = s; tod_min = m; tod_hour = h; tod_date = d;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    always @(posedge clk) tick_hist <= {tick_hist[0], sec_tick};

    // monitor: compares irq against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (tick_hist[1]) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R11: actual=unexpected tick expected=queued item");
                end else begin
                    check(tag_q.pop_front(), {7'd0, alarm_irq}, {7'd0, exp_q.pop_front()});
                end
            end else if (alarm_irq) begin
                check("R11", {7'd0, alarm_irq}, 8'd0);
            end
        end
    end

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", {7'd0, alarm_irq}, 8'd0);
        for (int i = 0; i < 5; i++) rd_check("R1", 3'(i), 8'h00);

        // R3 seconds / minutes
        wr(3'd0, 8'h59); rd_check("R3", 3'd0, 8'h59);
        wr(3'd0, 8'h60); rd_check("R3", 3'd0, 8'h59);
        wr(3'd0, 8'hD9); rd_check("R2", 3'd0, 8'hD9);
        wr(3'd1, 8'h00); rd_check("R3", 3'd1, 8'h00);
        wr(3'd1, 8'h5A); rd_check("R3", 3'd1, 8'h00);
        // R4 hours
        wr(3'd2, 8'h23); rd_check("R4", 3'd2, 8'h23);
        wr(3'd2, 8'h24); rd_check("R4", 3'd2, 8'h23);
        wr(3'd2, 8'h63); rd_check("R4", 3'd2, 8'h63);
        // R5 date
        wr(3'd3, 8'h31); rd_check("R5", 3'd3, 8'h31);
        wr(3'd3, 8'h00); rd_check("R5", 3'd3, 8'h31);
        wr(3'd3, 8'h40); rd_check("R5", 3'd3, 8'h31);
        // R2 enable and unmapped
        wr(3'd4, 8'hFF); rd_check("R2", 3'd4, 8'h80);
        wr(3'd5, 8'hFF); rd_check("R2", 3'd5, 8'h00);

        // alarm = 08:15:30 on date 12, masks clear
        wr(3'd0, 8'h30); wr(3'd1, 8'h15); wr(3'd2, 8'h08); wr(3'd3, 8'h12);
        tick("R6", 7'h30, 7'h15, 6'h08, 6'h12, 1'b1);
        tick("R6", 7'h30, 7'h15, 6'h08, 6'h13, 1'b0);
        tick("R6", 7'h31, 7'h15, 6'h08, 6'h12, 1'b0);
        // daily
        wr(3'd3, 8'h92);
        tick("R7", 7'h30, 7'h15, 6'h08, 6'h05, 1'b1);
        tick("R7", 7'h30, 7'h15, 6'h09, 6'h12, 1'b0);
        // hourly
        wr(3'd2, 8'h88);
        tick("R8", 7'h30, 7'h15, 6'h17, 6'h01, 1'b1);
        tick("R8", 7'h30, 7'h16, 6'h08, 6'h12, 1'b0);
        // once a minute
        wr(3'd1, 8'h95);
        tick("R9", 7'h30, 7'h44, 6'h02, 6'h02, 1'b1);
        tick("R9", 7'h29, 7'h15, 6'h08, 6'h12, 1'b0);
        // every second
        wr(3'd0, 8'hB0);
        tick("R10", 7'h01, 7'h02, 6'h03, 6'h04, 1'b1);
        wr(3'd1, 8'h15); wr(3'd2, 8'h08); wr(3'd3, 8'h12);
        tick("R10", 7'h01, 7'h02, 6'h03, 6'h04, 1'b1);
        // enable gating
        wr(3'd4, 8'h7F); rd_check("R12", 3'd4, 8'h00);
        tick("R12", 7'h30, 7'h15, 6'h08, 6'h12, 1'b0);
        wr(3'd4, 8'h80);
        tick("R11", 7'h30, 7'h15, 6'h08, 6'h12, 1'b1);

        repeat (5) @(negedge clk);
        check("R11", 8'(exp_q.size()), 8'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule